// File: doc/BRIEF.md
# Feedback-Free Parallel Stream Merger

This block merges two long integer streams, each already sorted from largest to smallest, into one stream sorted the same way, and emits P values per clock (P a power of two, 4 or more). Each input stream is delivered over P write lanes. Element k of a stream is written into lane k mod P, so every lane queue holds a sorted subsequence. Behind every queue sits one candidate register. Each cycle, lane i compares its stream A candidate with the stream B candidate fed from the mirrored queue P-1-i. It forwards the larger value and refills only the register it drew from. Equal values are taken from the B side.

The P forwarded values form a rotated bitonic sequence. They enter one pipelined half-merger of log2(P) compare-and-swap stages, which moves the larger value of each pair to the lower lane index. The output beat therefore has its largest value on lane 0. Nothing is fed back from the output side, and no rotation step is needed. The whole path is log2(2P) register stages deep.

Each stream has a done input that the producer raises after its last write. A lane whose queue is empty and whose stream is done supplies a zero sentinel, so real data values must be nonzero. Beats stop once every candidate holds a sentinel. `out_done` then rises when the pipeline has drained. The block stalls on a low `out_ready`, and also when a candidate must be refilled from an empty queue whose stream is not yet done.

Top module: `par_stream_merger`

## Requirements
- R1: After reset `out_valid` and `out_done` are low and every lane full flag is low.
- R2: In every valid beat the lane values never increase with lane index (lane 0 holds the largest).
- R3: Reading the accepted beats lane 0 first, beat after beat, gives the descending merge of both streams, duplicates and ties included, padded with zeros to a multiple of P. Stream element k must be written to lane k mod P.
- R4: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with `out_data` unchanged.
- R5: A done stream whose lane queue is empty contributes zero sentinels. For N real elements in total, exactly ceil(N/P) beats are produced, and lane 0 of every beat is nonzero.
- R6: `out_done` rises only after the last beat has been accepted. It is never high together with `out_valid`.
- R7: While any lane of a stream that is not done has an empty queue and an empty candidate, no beat leaves the block.
- R8: A lane full flag is high when that lane queue holds D entries. Writing a lane while its flag is high is not permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_push | input | P | Per-lane write strobe, stream A |
| a_wdata | input | P*W | Per-lane write data, stream A (lane j at bits j*W) |
| a_full | output | P | Per-lane queue full, stream A |
| a_done | input | 1 | Stream A has no further elements |
| b_push | input | P | Per-lane write strobe, stream B |
| b_wdata | input | P*W | Per-lane write data, stream B |
| b_full | output | P | Per-lane queue full, stream B |
| b_done | input | 1 | Stream B has no further elements |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | Beat on out_data is valid |
| out_data | output | P*W | Merged beat, lane 0 largest |
| out_done | output | 1 | All real elements have been emitted |

## Verification
Two activities can land in the same cycle: a consumer stall freezes the pipeline, while candidate registers drained on the previous fire are being refilled, either from their queue or with a zero sentinel. The bench provokes this by randomly dropping `out_ready` while the producers are still writing. It uses unequal stream lengths so that lanes run out at different times, and it delays one stream to force the empty-queue stall. Every accepted beat is compared against a merge computed in the bench. Each held beat is compared with the one seen before the stall, and the beat count and `out_done` timing are checked against ceil(N/P).

// File: rtl/psm_pkg.sv
package psm_pkg;
  // Lane of stream B that faces lane i of stream A.
  function automatic int unsigned mirror_lane(int unsigned i, int unsigned p);
    return p - 1 - i;
  endfunction

  // Lane that receives element k of a stream.
  function automatic int unsigned lane_of(int unsigned k, int unsigned p);
    return k % p;
  endfunction
endpackage

// File: rtl/psm_fifo.sv
module psm_fifo #(
  parameter int W = 32,
  parameter int D = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;

  logic [W-1:0] mem [D];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(logic [AW-1:0] p);
    return (p == AW'(D - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(D));
  assign rdata   = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      cnt <= cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/psm_halfmerge.sv
module psm_halfmerge #(
  parameter int P = 4,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           in_valid,
  input  logic [P*W-1:0] in_data,
  output logic           out_valid,
  output logic           busy,
  output logic [P*W-1:0] out_data
);
  localparam int L = $clog2(P);

  logic [W-1:0] inl [P];
  logic [W-1:0] r   [L][P];
  logic [W-1:0] nxt [L][P];
  logic [L-1:0] v;

  function automatic logic [W-1:0] hi(logic [W-1:0] x, logic [W-1:0] y);
    return (x > y) ? x : y;
  endfunction
  function automatic logic [W-1:0] lo(logic [W-1:0] x, logic [W-1:0] y);
    return (x > y) ? y : x;
  endfunction

  always_comb begin
    for (int j = 0; j < P; j++) inl[j] = in_data[j*W +: W];
  end

  // Stage s compares lanes a distance P>>(s+1) apart; larger goes low.
  always_comb begin
    for (int s = 0; s < L; s++) begin
      for (int j = 0; j < P; j++) begin
        int d;
        int pj;
        logic [W-1:0] x, y;
        d  = P >> (s + 1);
        pj = ((j & d) == 0) ? j + d : j - d;
        if (s == 0) begin
          x = inl[j];
          y = inl[pj];
        end else begin
          x = r[s-1][j];
          y = r[s-1][pj];
        end
        nxt[s][j] = ((j & d) == 0) ? hi(x, y) : lo(x, y);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int s = 0; s < L; s++)
        for (int j = 0; j < P; j++) r[s][j] <= nxt[s][j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) v <= '0;
    else if (en) v <= {v[L-2:0], in_valid};
  end

  always_comb begin
    for (int j = 0; j < P; j++) out_data[j*W +: W] = r[L-1][j];
  end
  assign out_valid = v[L-1];
  assign busy      = |v;

  for (genvar j = 0; j < P - 1; j++) begin : g_ord
    // R2
    desc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[j*W +: W] >= out_data[(j+1)*W +: W]));
  end
endmodule

// File: rtl/par_stream_merger.sv
module par_stream_merger #(
  parameter int P = 4,
  parameter int W = 32,
  parameter int D = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P-1:0]   a_push,
  input  logic [P*W-1:0] a_wdata,
  output logic [P-1:0]   a_full,
  input  logic           a_done,
  input  logic [P-1:0]   b_push,
  input  logic [P*W-1:0] b_wdata,
  output logic [P-1:0]   b_full,
  input  logic           b_done,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [P*W-1:0] out_data,
  output logic           out_done
);
  import psm_pkg::*;

  logic [W-1:0] a_head [P];
  logic [W-1:0] b_head [P];
  logic [P-1:0] a_empty, b_empty, a_pop, b_pop;

  for (genvar g = 0; g < P; g++) begin : g_q
    psm_fifo #(.W(W), .D(D)) u_qa (
      .clk(clk), .rst_n(rst_n), .push(a_push[g]), .wdata(a_wdata[g*W +: W]),
      .pop(a_pop[g]), .rdata(a_head[g]), .empty(a_empty[g]), .full(a_full[g]));
    psm_fifo #(.W(W), .D(D)) u_qb (
      .clk(clk), .rst_n(rst_n), .push(b_push[g]), .wdata(b_wdata[g*W +: W]),
      .pop(b_pop[g]), .rdata(b_head[g]), .empty(b_empty[g]), .full(b_full[g]));
  end

  // Candidate registers; cb[i] is fed by B queue mirror_lane(i).
  logic [W-1:0] ca [P];
  logic [W-1:0] cb [P];
  logic [P-1:0] ca_full, cb_full, ca_sent, cb_sent;
  logic [P-1:0] take_a, ca_free, cb_free;
  logic [W-1:0] pick [P];
  logic         all_full, all_sent, fire;

  assign all_full = (&ca_full) && (&cb_full);
  assign all_sent = (&ca_sent) && (&cb_sent);
  assign fire     = out_ready && all_full && !all_sent;

  always_comb begin
    b_pop = '0;
    for (int i = 0; i < P; i++) begin
      int m;
      m          = int'(mirror_lane(i, P));
      take_a[i]  = ca[i] > cb[i];
      pick[i]    = take_a[i] ? ca[i] : cb[i];
      ca_free[i] = !ca_full[i] || (fire && take_a[i]);
      cb_free[i] = !cb_full[i] || (fire && !take_a[i]);
      a_pop[i]   = ca_free[i] && !a_empty[i];
      b_pop[m]   = cb_free[i] && !b_empty[m];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_full <= '0; cb_full <= '0; ca_sent <= '0; cb_sent <= '0;
      for (int i = 0; i < P; i++) begin ca[i] <= '0; cb[i] <= '0; end
    end else begin
      for (int i = 0; i < P; i++) begin
        int m;
        m = int'(mirror_lane(i, P));
        if (ca_free[i]) begin
          if (!a_empty[i]) begin
            ca[i] <= a_head[i]; ca_full[i] <= 1'b1; ca_sent[i] <= 1'b0;
          end else if (a_done) begin
            ca[i] <= '0; ca_full[i] <= 1'b1; ca_sent[i] <= 1'b1;
          end else ca_full[i] <= 1'b0;
        end
        if (cb_free[i]) begin
          if (!b_empty[m]) begin
            cb[i] <= b_head[m]; cb_full[i] <= 1'b1; cb_sent[i] <= 1'b0;
          end else if (b_done) begin
            cb[i] <= '0; cb_full[i] <= 1'b1; cb_sent[i] <= 1'b1;
          end else cb_full[i] <= 1'b0;
        end
      end
    end
  end

  // Select stage register.
  logic [W-1:0]   sel_data [P];
  logic [P*W-1:0] sel_bus;
  logic           sel_valid, net_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_valid <= 1'b0;
    else if (out_ready) sel_valid <= fire;
  end
  always_ff @(posedge clk) begin
    if (out_ready)
      for (int i = 0; i < P; i++) sel_data[i] <= pick[i];
  end
  always_comb begin
    for (int i = 0; i < P; i++) sel_bus[i*W +: W] = sel_data[i];
  end

  psm_halfmerge #(.P(P), .W(W)) u_net (
    .clk(clk), .rst_n(rst_n), .en(out_ready), .in_valid(sel_valid),
    .in_data(sel_bus), .out_valid(out_valid), .busy(net_busy),
    .out_data(out_data));

  assign out_done = all_full && all_sent && !sel_valid && !net_busy;

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  real_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[W-1:0] != '0));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !out_valid);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && a_done && b_done) |=> out_done);
endmodule

// File: tb/par_stream_merger_test.sv
module par_stream_merger_test;
  localparam int P = 4;
  localparam int W = 32;
  localparam int D = 8;
  localparam int MAXN = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic [P-1:0] a_push = '0, b_push = '0, a_full, b_full;
  logic [P*W-1:0] a_wdata = '0, b_wdata = '0, out_data;
  logic a_done = 0, b_done = 0, out_ready = 0, out_valid, out_done;

  par_stream_merger #(.P(P), .W(W), .D(D)) uut (
    .clk(clk), .rst_n(rst_n), .a_push(a_push), .a_wdata(a_wdata),
    .a_full(a_full), .a_done(a_done), .b_push(b_push), .b_wdata(b_wdata),
    .b_full(b_full), .b_done(b_done), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_done(out_done));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int va [MAXN];
  int vb [MAXN];
  int refv [2*MAXN + P];
  bit wd_hit = 0;

  task automatic chk(bit ok, string req, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; a_push = '0; b_push = '0; a_done = 0; b_done = 0; out_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic make_stream(int n, ref int arr [MAXN]);
    int v;
    v = $urandom_range(1, 3);
    for (int k = n - 1; k >= 0; k--) begin
      arr[k] = v;
      v += $urandom_range(0, 2);
    end
  endtask

  // Descending reference merge, zero padded to a multiple of P.
  task automatic make_ref(int na, int nb);
    int i = 0, j = 0, k = 0;
    while (i < na || j < nb) begin
      if (j >= nb || (i < na && va[i] >= vb[j])) begin refv[k] = va[i]; i++; end
      else begin refv[k] = vb[j]; j++; end
      k++;
    end
    while (k % P != 0) begin refv[k] = 0; k++; end
  endtask

  task automatic feed_a(int n);
    int pa = 0;
    while (pa < n) begin
      @(negedge clk);
      a_push = '0;
      for (int s = 0; s < P && pa < n; s++) begin
        int ln = pa % P;
        if (a_full[ln]) break;
        a_push[ln] = 1'b1;
        a_wdata[ln*W +: W] = W'(va[pa]);
        pa++;
      end
    end
    @(negedge clk);
    a_push = '0;
    a_done = 1;
  endtask

  task automatic feed_b(int n, int delay);
    int pb = 0;
    repeat (delay) @(negedge clk);
    while (pb < n) begin
      @(negedge clk);
      b_push = '0;
      for (int s = 0; s < P && pb < n; s++) begin
        int ln = pb % P;
        if (b_full[ln]) break;
        b_push[ln] = 1'b1;
        b_wdata[ln*W +: W] = W'(vb[pb]);
        pb++;
      end
    end
    @(negedge clk);
    b_push = '0;
    b_done = 1;
  endtask

  task automatic collect(int n, int delay, bit stall);
    int beats = 0, cyc = 0;
    int expb;
    bit held = 0, early = 0;
    logic [P*W-1:0] last = '0;
    expb = (n + P - 1) / P;
    while (!out_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (out_done) break;
      if (held) begin
        chk(out_valid && out_data == last, "R4",
            $sformatf("held beat %h valid %0d, expected %h valid 1", out_data, out_valid, last));
      end
      out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
      held = out_valid && !out_ready;
      last = out_data;
      if (out_valid && out_ready) begin
        bit ok = 1;
        if (delay > 0 && cyc <= delay) early = 1;
        for (int j = 0; j < P; j++) begin
          if (beats*P + j < 2*MAXN + P && out_data[j*W +: W] != W'(refv[beats*P + j])) ok = 0;
          if (j > 0 && out_data[j*W +: W] > out_data[(j-1)*W +: W]) ok = 0;
        end
        chk(ok && beats < expb, "R2/R3",
            $sformatf("beat %0d got %h, expected %0d %0d %0d %0d", beats, out_data,
                      refv[beats*P], refv[beats*P+1], refv[beats*P+2], refv[beats*P+3]));
        beats++;
      end
    end
    chk(out_done && !out_valid, "R6",
        $sformatf("done %0d valid %0d, expected 1 0", out_done, out_valid));
    chk(beats == expb, "R5", $sformatf("beats %0d, expected %0d", beats, expb));
    if (delay > 0 && n > 0)
      chk(!early, "R7", $sformatf("beat before B arrived %0d, expected 0", early));
  endtask

  task automatic run_case(int na, int nb, int delay, bit stall);
    do_reset();
    make_stream(na, va);
    make_stream(nb, vb);
    make_ref(na, nb);
    fork
      feed_a(na);
      feed_b(nb, delay);
      collect(na + nb, delay, stall);
    join
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    wd_hit = 1;
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    chk(!out_valid && !out_done && a_full == '0 && b_full == '0, "R1",
        $sformatf("valid %0d done %0d afull %b bfull %b, expected all 0",
                  out_valid, out_done, a_full, b_full));

    // R8: fill lane 0 of A with no B data; candidate takes one, queue takes D.
    for (int k = 0; k < D + 1; k++) begin
      a_push = 4'b0001; a_wdata[W-1:0] = W'(100 - k);
      @(negedge clk);
    end
    a_push = '0;
    repeat (2) @(negedge clk);
    chk(a_full == 4'b0001, "R8", $sformatf("a_full %b, expected 0001", a_full));
    chk(!out_valid, "R7", $sformatf("valid %0d with B empty, expected 0", out_valid));

    run_case(8, 8, 0, 0);
    run_case(17, 5, 0, 1);
    run_case(1, 0, 0, 0);
    run_case(0, 3, 0, 1);
    run_case(0, 0, 0, 0);
    run_case(32, 32, 0, 1);
    run_case(12, 20, 20, 1);
    run_case(5, 9, 15, 0);
    for (int t = 0; t < 12; t++)
      run_case($urandom_range(0, MAXN), $urandom_range(0, MAXN), (t % 3 == 0) ? 12 : 0, t[0]);

    if (!wd_hit) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule